// File: doc/BRIEF.md
# Segment-Controlled Address Translator

This block turns a 32-bit virtual address into one of three outcomes: a direct physical address, a request that the address be looked up in the page table cache, or an address fault. The top three address bits pick one of six 16-bit segment words out of three 32-bit control inputs. The access-mode field of that word, read against the current privilege level, decides whether the segment is mapped, unmapped or forbidden. The run-time configuration replaces a fixed segment map, so software can give each region any of these behaviours.

For an unmapped access, the block builds the physical address from the segment's base field and the offset bits of the virtual address, and grants full permissions. A request is presented with `in_valid`. The result appears on the registered outputs one clock later, marked by a one-cycle `out_valid` pulse. The lookup itself, caches and any debug window are handled elsewhere.

Top module: `seg_xlate`

## Requirements
- R1: Addresses with bit 31 clear use an offset mask of 0x3FFFFFFF. Those with bit 30 set take the segment word from `in_ctl2[15:0]`, and those with bit 30 clear take it from `in_ctl2[31:16]`.
- R2: The other addresses use an offset mask of 0x1FFFFFFF. The segment word comes from `in_ctl1[31:16]` for 0x80000000–0x9FFFFFFF, `in_ctl1[15:0]` for 0xA0000000–0xBFFFFFFF, `in_ctl0[31:16]` for 0xC0000000–0xDFFFFFFF and `in_ctl0[15:0]` for 0xE0000000 and up.
- R3: Segment word layout: base in bits 15:9, access mode in bits 6:4, unmap-at-error-level flag in bit 3, cache attribute in bits 2:0. Privilege code 2'b00 (kernel) never faults, and it requests a lookup only for modes 1, 2 and 3.
- R4: With privilege code 2'b11 (error level), a set bit 3 makes the segment unmapped. With bit 3 clear, the result equals the kernel result.
- R5: With privilege code 2'b01 (supervisor), modes 0 and 1 fault, modes 2, 3 and 4 request a lookup, and the rest are unmapped.
- R6: With privilege code 2'b10 (user), modes 0, 1, 2 and 5 fault, modes 3 and 4 request a lookup, and modes 6 and 7 are unmapped.
- R7: Mode 6 is unmapped at every privilege level, whatever bit 3 holds.
- R8: An unmapped result has this physical address: the segment word's bits 15:9, shifted to bits 35:29 with the offset-mask bits cleared, ORed with the address ANDed with the offset mask. Its permission output is 3'b111 (execute, write, read). Any other result drives the physical address and the permission output to 0.
- R9: `out_attr` carries bits 2:0 of the selected segment word for every result.
- R10: `out_res` uses 2'b00 for unmapped, 2'b01 for lookup required and 2'b10 for fault, and never 2'b11. The results appear on the clock edge after the one that samples `in_valid`, and `out_valid` is high for exactly one cycle per request. Reset clears every output to 0.
- R11: While `in_valid` is low, all result outputs keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_addr | input | 32 | Virtual address |
| in_priv | input | 2 | Privilege code (00 kernel, 01 supervisor, 10 user, 11 error level) |
| in_ctl0 | input | 32 | Segment words for the two highest regions |
| in_ctl1 | input | 32 | Segment words for 0x80000000–0xBFFFFFFF |
| in_ctl2 | input | 32 | Segment words for the lower half |
| out_valid | output | 1 | One-cycle result strobe |
| out_res | output | 2 | Result code |
| out_phys | output | 36 | Physical address for unmapped results |
| out_perm | output | 3 | Permissions {execute, write, read} |
| out_attr | output | 3 | Cache attribute of the selected segment |

## Verification
The hardest case to reach is a privilege level and access mode arriving in exactly the region whose segment word carries them. Only one of the six words is live for a given address, so random control words alone rarely reach each combination. The stimulus therefore sweeps every privilege level, every mode, both flag values and all six regions. For each case it fills the control inputs with random data and then forces only the word that the chosen region selects, which also shows that the other five words are ignored. Idle cycles with scrambled inputs sit between requests to expose any output that fails to hold.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    PRIV_KERN  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_USER  = 2'b10,
    PRIV_ERRL  = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    RES_HIT   = 2'b00,
    RES_TLB   = 2'b01,
    RES_FAULT = 2'b10
  } res_e;

  // 16-bit segment word
  typedef struct packed {
    logic [6:0] base;
    logic [1:0] spare;
    logic [2:0] mode;
    logic       ex_unmap;
    logic [2:0] attr;
  } seg_cfg_t;

  localparam int CFG_W    = $bits(seg_cfg_t);
  localparam int BASE_LSB = 9;
  localparam int PERM_W   = 3;

endpackage

// File: rtl/seg_xlate_pick.sv
module seg_xlate_pick
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NCTL   = 3
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [2*CFG_W-1:0] ctl [NCTL],
  output seg_cfg_t           cfg,
  output logic [ADDR_W-1:0]  off_mask
);
  localparam int NSLOT = 2 * NCTL;
  localparam logic [ADDR_W-1:0] LOW_MASK  = {2'b00, {(ADDR_W-2){1'b1}}};
  localparam logic [ADDR_W-1:0] HIGH_MASK = {3'b000, {(ADDR_W-3){1'b1}}};

  logic [CFG_W-1:0] slot [NSLOT];
  logic [2:0]       top3;
  logic [2:0]       idx;

  // slot 2g = upper half of control word g, slot 2g+1 = lower half
  for (genvar g = 0; g < NCTL; g++) begin : g_unpack
    assign slot[2*g]   = ctl[g][2*CFG_W-1:CFG_W];
    assign slot[2*g+1] = ctl[g][CFG_W-1:0];
  end

  assign top3 = addr[ADDR_W-1 -: 3];

  always_comb begin
    if (top3[2]) begin
      idx      = {1'b0, ~top3[1], top3[0]};
      off_mask = HIGH_MASK;
    end else begin
      idx      = {2'b10, top3[1]};
      off_mask = LOW_MASK;
    end
    cfg = seg_cfg_t'(slot[idx]);
  end

endmodule

// File: rtl/seg_xlate_mode.sv
module seg_xlate_mode
  import seg_xlate_pkg::*;
(
  input  priv_e      priv,
  input  logic [2:0] mode,
  input  logic       ex_unmap,
  output res_e       kind
);
  // bit n set: access mode n is affected
  localparam logic [7:0] K_FAULT = 8'b0000_0000;
  localparam logic [7:0] K_MAP   = 8'b0000_1110;
  localparam logic [7:0] S_FAULT = 8'b0000_0011;
  localparam logic [7:0] S_MAP   = 8'b0001_1100;
  localparam logic [7:0] U_FAULT = 8'b0010_0111;
  localparam logic [7:0] U_MAP   = 8'b0001_1000;

  logic [7:0] fault_set;
  logic [7:0] map_set;

  always_comb begin
    unique case (priv)
      PRIV_SUPER: begin fault_set = S_FAULT; map_set = S_MAP; end
      PRIV_USER:  begin fault_set = U_FAULT; map_set = U_MAP; end
      default:    begin fault_set = K_FAULT; map_set = K_MAP; end
    endcase

    if (priv == PRIV_ERRL && ex_unmap) kind = RES_HIT;
    else if (fault_set[mode])          kind = RES_FAULT;
    else if (map_set[mode])            kind = RES_TLB;
    else                               kind = RES_HIT;
  end

endmodule

// File: rtl/seg_xlate_form.sv
module seg_xlate_form
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PA_SHIFT = 20,
  parameter int PHYS_W   = CFG_W + PA_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [6:0]        base,
  input  logic [ADDR_W-1:0] off_mask,
  output logic [PHYS_W-1:0] phys
);
  localparam int BASE_POS = BASE_LSB + PA_SHIFT;

  logic [PHYS_W-1:0] base_w;
  logic [PHYS_W-1:0] mask_w;
  logic [PHYS_W-1:0] addr_w;

  assign base_w = {{(PHYS_W-7){1'b0}}, base} << BASE_POS;
  assign mask_w = {{(PHYS_W-ADDR_W){1'b0}}, off_mask};
  assign addr_w = {{(PHYS_W-ADDR_W){1'b0}}, addr};
  assign phys   = (base_w & ~mask_w) | (addr_w & mask_w);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PA_SHIFT = 20,
  parameter int PHYS_W   = CFG_W + PA_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [ADDR_W-1:0]    in_addr,
  input  logic [1:0]           in_priv,
  input  logic [2*CFG_W-1:0]   in_ctl0,
  input  logic [2*CFG_W-1:0]   in_ctl1,
  input  logic [2*CFG_W-1:0]   in_ctl2,
  output logic                 out_valid,
  output logic [1:0]           out_res,
  output logic [PHYS_W-1:0]    out_phys,
  output logic [PERM_W-1:0]    out_perm,
  output logic [2:0]           out_attr
);
  localparam int NCTL = 3;

  logic [2*CFG_W-1:0] ctl [NCTL];
  seg_cfg_t           cfg;
  logic [ADDR_W-1:0]  off_mask;
  res_e               kind;
  logic [PHYS_W-1:0]  phys_c;

  assign ctl[0] = in_ctl0;
  assign ctl[1] = in_ctl1;
  assign ctl[2] = in_ctl2;

  seg_xlate_pick #(.ADDR_W(ADDR_W), .NCTL(NCTL)) u_pick (
    .addr     (in_addr),
    .ctl      (ctl),
    .cfg      (cfg),
    .off_mask (off_mask)
  );

  seg_xlate_mode u_mode (
    .priv     (priv_e'(in_priv)),
    .mode     (cfg.mode),
    .ex_unmap (cfg.ex_unmap),
    .kind     (kind)
  );

  seg_xlate_form #(.ADDR_W(ADDR_W), .PA_SHIFT(PA_SHIFT), .PHYS_W(PHYS_W)) u_form (
    .addr     (in_addr),
    .base     (cfg.base),
    .off_mask (off_mask),
    .phys     (phys_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_res   <= RES_HIT;
      out_phys  <= '0;
      out_perm  <= '0;
      out_attr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res  <= kind;
        out_attr <= cfg.attr;
        if (kind == RES_HIT) begin
          out_phys <= phys_c;
          out_perm <= '1;
        end else begin
          out_phys <= '0;
          out_perm <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 32,
  parameter int PHYS_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic [1:0]        in_priv,
  input logic              out_valid,
  input logic [1:0]        out_res,
  input logic [PHYS_W-1:0] out_phys,
  input logic [2:0]        out_perm
);
  // R10: strobe follows the request by one cycle
  a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r10_code: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_res != 2'b11);
  // R11: results hold while idle
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_res) && $stable(out_phys) && $stable(out_perm)));
  // R3: kernel never faults
  a_r3_kern_nofault: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_priv == 2'b00) |=> out_res != 2'b10);
  // R8: permissions tied to the result kind
  a_r8_perm_full: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_res == 2'b00) |-> out_perm == 3'b111);
  a_r8_perm_none: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_res != 2'b00) |-> (out_perm == 3'b000 && out_phys == '0));
  // R1: lower-half offset passes through unchanged
  a_r1_low_offset: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_addr[ADDR_W-1]) |=>
      (out_res != 2'b00 || out_phys[ADDR_W-3:0] == $past(in_addr[ADDR_W-3:0])));
endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_addr   (in_addr),
  .in_priv   (in_priv),
  .out_valid (out_valid),
  .out_res   (out_res),
  .out_phys  (out_phys),
  .out_perm  (out_perm)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic [1:0]  in_priv = '0;
  logic [31:0] in_ctl0 = '0, in_ctl1 = '0, in_ctl2 = '0;
  logic        out_valid;
  logic [1:0]  out_res;
  logic [35:0] out_phys;
  logic [2:0]  out_perm;
  logic [2:0]  out_attr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_tag = "R10";

  always #2 clk = ~clk;

  seg_xlate u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .in_priv(in_priv), .in_ctl0(in_ctl0), .in_ctl1(in_ctl1), .in_ctl2(in_ctl2),
    .out_valid(out_valid), .out_res(out_res), .out_phys(out_phys),
    .out_perm(out_perm), .out_attr(out_attr)
  );

  // ---------------- reference model ----------------
  function automatic logic [15:0] ref_word(input logic [31:0] a,
      input logic [31:0] c0, c1, c2);
    if (a < 32'h4000_0000)      return c2[31:16];
    else if (a < 32'h8000_0000) return c2[15:0];
    else if (a < 32'hA000_0000) return c1[31:16];
    else if (a < 32'hC000_0000) return c1[15:0];
    else if (a < 32'hE000_0000) return c0[31:16];
    else                        return c0[15:0];
  endfunction

  function automatic logic [1:0] ref_kind(input int pv, input int am, input bit eu);
    if (pv == 3 && eu) return 2'b00;
    case (pv)
      1: begin
        if (am inside {0, 1}) return 2'b10;
        if (am inside {2, 3, 4}) return 2'b01;
        return 2'b00;
      end
      2: begin
        if (am inside {0, 1, 2, 5}) return 2'b10;
        if (am inside {3, 4}) return 2'b01;
        return 2'b00;
      end
      default: begin
        if (am inside {1, 2, 3}) return 2'b01;
        return 2'b00;
      end
    endcase
  endfunction

  logic        e_valid;
  logic [1:0]  e_res;
  logic [35:0] e_phys;
  logic [2:0]  e_perm, e_attr;
  string       e_tag;

  always @(posedge clk) begin
    if (rst) begin
      e_valid = 0; e_res = 0; e_phys = 0; e_perm = 0; e_attr = 0; e_tag = "R10";
    end else begin
      e_valid = in_valid;
      if (in_valid) begin
        logic [15:0] w;
        longint mask, base, ph;
        w    = ref_word(in_addr, in_ctl0, in_ctl1, in_ctl2);
        mask = (in_addr < 32'h8000_0000) ? 64'h3FFF_FFFF : 64'h1FFF_FFFF;
        base = (longint'(w) & 64'hFE00) << 20;
        ph   = (base & ~mask) | (longint'(in_addr) & mask);
        e_res  = ref_kind(int'(in_priv), int'(w[6:4]), w[3]);
        e_attr = w[2:0];
        e_phys = (e_res == 2'b00) ? ph[35:0] : 36'h0;
        e_perm = (e_res == 2'b00) ? 3'b111 : 3'b000;
        e_tag  = cur_tag;
      end else begin
        e_tag = "R11";
      end
    end
  end

  task automatic cmp(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      cmp("R10", "out_valid", longint'(out_valid), longint'(e_valid));
      cmp(e_tag, "out_res",   longint'(out_res),   longint'(e_res));
      cmp(e_tag == "R11" ? "R11" : "R8", "out_phys", longint'(out_phys), longint'(e_phys));
      cmp(e_tag == "R11" ? "R11" : "R8", "out_perm", longint'(out_perm), longint'(e_perm));
      cmp(e_tag == "R11" ? "R11" : "R9", "out_attr", longint'(out_attr), longint'(e_attr));
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [15:0] mk(input logic [6:0] pa, input int am,
      input bit eu, input logic [2:0] cca);
    return {pa, 2'b00, 3'(am), eu, cca};
  endfunction

  function automatic logic [31:0] reg_addr(input int r, input logic [31:0] rnd);
    case (r)
      0: return {2'b00, rnd[29:0]};
      1: return {2'b01, rnd[29:0]};
      2: return {3'b100, rnd[28:0]};
      3: return {3'b101, rnd[28:0]};
      4: return {3'b110, rnd[28:0]};
      default: return {3'b111, rnd[28:0]};
    endcase
  endfunction

  task automatic send(input int r, input int pv, input int am, input bit eu, input string tag);
    logic [31:0] c0, c1, c2;
    logic [15:0] w;
    @(negedge clk);
    c0 = $urandom; c1 = $urandom; c2 = $urandom;
    w = mk(7'($urandom), am, eu, 3'($urandom));
    case (r)
      0: c2[31:16] = w;
      1: c2[15:0]  = w;
      2: c1[31:16] = w;
      3: c1[15:0]  = w;
      4: c0[31:16] = w;
      default: c0[15:0] = w;
    endcase
    in_ctl0 = c0; in_ctl1 = c1; in_ctl2 = c2;
    in_addr = reg_addr(r, $urandom);
    in_priv = 2'(pv);
    in_valid = 1'b1;
    cur_tag = tag;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_addr = $urandom; in_priv = 2'($urandom);
    in_ctl0 = $urandom; in_ctl1 = $urandom; in_ctl2 = $urandom;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    cmp("R10", "reset out_valid", longint'(out_valid), 0);
    cmp("R10", "reset out_res",   longint'(out_res), 0);
    cmp("R10", "reset out_phys",  longint'(out_phys), 0);
    cmp("R10", "reset out_perm",  longint'(out_perm), 0);
    rst = 1'b0;

    // R1 / R2: region selection and offset masks, kernel, unmapped mode 0
    for (int r = 0; r < 6; r++)
      for (int k = 0; k < 4; k++) send(r, 0, 0, 0, r < 2 ? "R1" : "R2");

    // R3..R6: every privilege, mode, flag and region
    for (int pv = 0; pv < 4; pv++)
      for (int am = 0; am < 8; am++)
        for (int eu = 0; eu < 2; eu++)
          for (int r = 0; r < 6; r++) begin
            string t;
            t = (am == 6) ? "R7" : (pv == 0) ? "R3" : (pv == 3) ? "R4" :
                (pv == 1) ? "R5" : "R6";
            send(r, pv, am, eu[0], t);
            if ((am + r) % 3 == 0) idle();
          end

    // R7: reserved mode everywhere
    for (int pv = 0; pv < 4; pv++)
      for (int r = 0; r < 6; r++) send(r, pv, 6, pv[0], "R7");

    // R8 / R9 / R11: random mixture with idle gaps
    for (int i = 0; i < 400; i++) begin
      send(int'($urandom_range(0, 5)), int'($urandom_range(0, 3)),
           int'($urandom_range(0, 7)), 1'($urandom), "R8");
      if ($urandom_range(0, 2) == 0) begin
        idle();
        idle();
      end
    end

    idle();
    idle();
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule